// File: doc/BRIEF.md
# Bit-Slice Integer ALU with Signed Set-Less-Than

A purely combinational integer ALU for a single-issue RISC datapath. It is built as a chain of 1-bit slices, each with an AND gate, an OR gate, a full adder and a result multiplexer. The carries ripple from slice 0 to the sign slice. The sign slice is a variant of the ordinary slice. It also produces the overflow flag and the "set" bit that drives signed compare.

A 4-bit control selects the operation. Bit 3 inverts A, bit 2 inverts B and also forces the carry into slice 0, and bits 1:0 choose what each slice's multiplexer passes to the result. Subtraction uses B inversion with a carry-in of 1. NOR is AND with both operands inverted. Set-less-than routes the sign slice's corrected sign of A−B into the "less" input of slice 0; every other slice gets 0 on that input. The correction XORs the sign with the overflow flag, so the compare stays right when A−B overflows. A zero detector reduces the result.

Top module: `slice_alu`

## Requirements
- R1: Control 4'b0000 gives result_o = a_i AND b_i.
- R2: Control 4'b0001 gives result_o = a_i OR b_i.
- R3: Control 4'b0010 gives result_o = (a_i + b_i) mod 2^32, and cout_o is the carry out of bit 31 of that sum.
- R4: Control 4'b0110 gives result_o = (a_i − b_i) mod 2^32, and cout_o = 1 exactly when a_i ≥ b_i as unsigned values (no borrow).
- R5: Control 4'b0111 gives result_o = 1 when a_i < b_i as signed two's complement values and 0 otherwise. Bits 31:1 are always 0. This holds for the extreme operands 0x80000000 and 0x7FFFFFFF.
- R6: Control 4'b1100 gives result_o = NOT (a_i OR b_i).
- R7: ovf_o is 1 exactly when the adder's signed result overflows, for add (0010) and for subtract or set-less-than (0110, 0111).
- R8: zero_o is 1 exactly when all 32 bits of result_o are 0, for every control value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| ctrl_i | input | 4 | {invert A, invert B and carry-in, operation select[1:0]} |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Signed overflow of the sign slice's adder |
| cout_o | output | 1 | Carry out of the sign slice's adder |

## Verification
The immediate assertions check properties that hold on any operands. The zero flag must agree with the result. The set-less-than result may use only bit 0. Subtract carry-out must equal the unsigned compare. AND must match its operands, and overflow on add may appear only when both operand signs agree and the sum sign differs from them. The bench's scenarios cover the rest. These are the exact sums, differences and NOR values, and signed compare at the overflow extremes (0x80000000 against 0x7FFFFFFF and against 1). They also include carry out of an all-ones add, and a zero result produced by subtracting equal values.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;
  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } sel_e;

  localparam logic [3:0] CTRL_AND = 4'b0000;
  localparam logic [3:0] CTRL_OR  = 4'b0001;
  localparam logic [3:0] CTRL_ADD = 4'b0010;
  localparam logic [3:0] CTRL_SUB = 4'b0110;
  localparam logic [3:0] CTRL_SLT = 4'b0111;
  localparam logic [3:0] CTRL_NOR = 4'b1100;
endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import slice_alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       inv_a_i,
  input  logic       inv_b_i,
  input  logic       cin_i,
  input  logic       less_i,
  input  logic [1:0] sel_i,
  output logic       res_o,
  output logic       sum_o,
  output logic       cout_o
);
  logic a_x, b_x;

  assign a_x    = a_i ^ inv_a_i;
  assign b_x    = b_i ^ inv_b_i;
  assign sum_o  = a_x ^ b_x ^ cin_i;
  assign cout_o = (a_x & b_x) | (cin_i & (a_x ^ b_x));

  always_comb begin
    unique case (sel_e'(sel_i))
      SEL_AND:  res_o = a_x & b_x;
      SEL_OR:   res_o = a_x | b_x;
      SEL_SUM:  res_o = sum_o;
      default:  res_o = less_i;
    endcase
  end
endmodule

// File: rtl/alu_sign_slice.sv
module alu_sign_slice (
  input  logic       a_i,
  input  logic       b_i,
  input  logic       inv_a_i,
  input  logic       inv_b_i,
  input  logic       cin_i,
  input  logic       less_i,
  input  logic [1:0] sel_i,
  output logic       res_o,
  output logic       cout_o,
  output logic       set_o,
  output logic       ovf_o
);
  logic sum;

  alu_bit_slice u_core (
    .a_i     (a_i),
    .b_i     (b_i),
    .inv_a_i (inv_a_i),
    .inv_b_i (inv_b_i),
    .cin_i   (cin_i),
    .less_i  (less_i),
    .sel_i   (sel_i),
    .res_o   (res_o),
    .sum_o   (sum),
    .cout_o  (cout_o)
  );

  assign ovf_o = cin_i ^ cout_o;
  // sign corrected by overflow keeps signed compare exact
  assign set_o = sum ^ ovf_o;
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] val_i,
  output logic             zero_o
);
  assign zero_o = ~(|val_i);
endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import slice_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       ctrl_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             cout_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic             inv_a, inv_b;
  logic [1:0]       sel;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] less;
  logic [WIDTH-1:0] sum_unused;
  logic             set_bit;

  assign inv_a    = ctrl_i[3];
  assign inv_b    = ctrl_i[2];
  assign sel      = ctrl_i[1:0];
  assign carry[0] = inv_b;
  assign less     = {{(WIDTH-1){1'b0}}, set_bit};

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    if (i == MSB) begin : g_sign
      alu_sign_slice u_slice (
        .a_i     (a_i[i]),
        .b_i     (b_i[i]),
        .inv_a_i (inv_a),
        .inv_b_i (inv_b),
        .cin_i   (carry[i]),
        .less_i  (less[i]),
        .sel_i   (sel),
        .res_o   (result_o[i]),
        .cout_o  (carry[i+1]),
        .set_o   (set_bit),
        .ovf_o   (ovf_o)
      );
      assign sum_unused[i] = 1'b0;
    end else begin : g_plain
      alu_bit_slice u_slice (
        .a_i     (a_i[i]),
        .b_i     (b_i[i]),
        .inv_a_i (inv_a),
        .inv_b_i (inv_b),
        .cin_i   (carry[i]),
        .less_i  (less[i]),
        .sel_i   (sel),
        .res_o   (result_o[i]),
        .sum_o   (sum_unused[i]),
        .cout_o  (carry[i+1])
      );
    end
  end

  assign cout_o = carry[WIDTH];

  alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .val_i  (result_o),
    .zero_o (zero_o)
  );

  always_comb begin
    if (!$isunknown({a_i, b_i, ctrl_i})) begin
      a_r8_zero_flag: assert (zero_o == (result_o == '0))
        else $error("zero flag disagrees with result");
      if (ctrl_i == CTRL_SLT) begin
        a_r5_slt_upper_zero: assert (result_o[WIDTH-1:1] == '0)
          else $error("set-less-than upper bits nonzero");
      end
      if (ctrl_i == CTRL_SUB) begin
        a_r4_sub_no_borrow: assert (cout_o == (a_i >= b_i))
          else $error("subtract carry disagrees with unsigned compare");
      end
      if (ctrl_i == CTRL_AND) begin
        a_r1_and_bits: assert (result_o == (a_i & b_i))
          else $error("AND result wrong");
      end
      if (ctrl_i == CTRL_ADD && ovf_o) begin
        a_r7_add_overflow: assert (a_i[MSB] == b_i[MSB] && result_o[MSB] != a_i[MSB])
          else $error("overflow flagged without sign flip");
      end
    end
  end
endmodule

// File: tb/tb_slice_alu.sv
`timescale 1ns/1ps
module tb_slice_alu;
  localparam int W = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] a, b, res;
  logic [3:0]   ctrl;
  logic         zero, ovf, cout;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  slice_alu #(.WIDTH(W)) dut (
    .a_i(a), .b_i(b), .ctrl_i(ctrl),
    .result_o(res), .zero_o(zero), .ovf_o(ovf), .cout_o(cout)
  );

  function automatic string tag_of(logic [3:0] c);
    case (c)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [W-1:0] exp_res(logic [W-1:0] x, logic [W-1:0] y, logic [3:0] c);
    case (c)
      4'b0000: return x & y;
      4'b0001: return x | y;
      4'b0010: return x + y;
      4'b0110: return x - y;
      4'b0111: return ($signed(x) < $signed(y)) ? 1 : 0;
      default: return ~(x | y);
    endcase
  endfunction

  function automatic logic exp_cout(logic [W-1:0] x, logic [W-1:0] y, logic [3:0] c);
    logic [W:0] s;
    if (c == 4'b0010) s = {1'b0, x} + {1'b0, y};
    else if (c[2] && !c[3]) return (x >= y);
    else s = {1'b0, c[3] ? ~x : x} + {1'b0, c[2] ? ~y : y} + (W+1)'(c[2]);
    return s[W];
  endfunction

  function automatic logic exp_ovf(logic [W-1:0] x, logic [W-1:0] y, logic [3:0] c);
    longint sx, sy, r;
    sx = longint'($signed(c[3] ? ~x : x));
    sy = longint'($signed(y));
    if (c[2]) r = sx - sy; else r = sx + sy;
    return (r > 64'sd2147483647) || (r < -64'sd2147483648);
  endfunction

  task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: a=%h b=%h ctrl=%b actual=%h expected=%h", tag, what, a, b, ctrl, act, exp);
    end
  endtask

  task automatic apply(logic [W-1:0] x, logic [W-1:0] y, logic [3:0] c);
    logic [W-1:0] er;
    @(negedge clk);
    a = x; b = y; ctrl = c;
    #1;
    er = exp_res(x, y, c);
    check(tag_of(c), "result", res, er);
    check("R8", "zero", W'(zero), W'(er == '0));
    if (c == 4'b0010 || c == 4'b0110 || c == 4'b0111)
      check("R7", "ovf", W'(ovf), W'(exp_ovf(x, y, c)));
    if (c == 4'b0010) check("R3", "cout", W'(cout), W'(exp_cout(x, y, c)));
    if (c == 4'b0110) check("R4", "cout", W'(cout), W'(exp_cout(x, y, c)));
  endtask

  localparam logic [3:0] OPS [6] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};

  initial begin
    void'($urandom(32'h5A17_C0DE));
    a = '0; b = '0; ctrl = 4'b0000;
    #2;
    // reset-like idle state: AND of zeros
    check("R8", "idle zero", W'(zero), W'(1));
    check("R1", "idle result", res, '0);
    // R5 signed compare at overflow extremes
    apply(32'h8000_0000, 32'h7FFF_FFFF, 4'b0111);
    apply(32'h7FFF_FFFF, 32'h8000_0000, 4'b0111);
    apply(32'h8000_0000, 32'h0000_0001, 4'b0111);
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111);
    apply(32'h1234_5678, 32'h1234_5678, 4'b0111);
    // R7 overflow corners
    apply(32'h7FFF_FFFF, 32'h0000_0001, 4'b0010);
    apply(32'h8000_0000, 32'h8000_0000, 4'b0010);
    apply(32'h8000_0000, 32'h0000_0001, 4'b0110);
    // R3 carry out of all-ones, R4 equal subtract gives zero (R8)
    apply(32'hFFFF_FFFF, 32'h0000_0001, 4'b0010);
    apply(32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'b0110);
    apply(32'h0000_0000, 32'h0000_0001, 4'b0110);
    // R6 NOR of zeros and ones, R2 OR, R1 AND
    apply(32'h0000_0000, 32'h0000_0000, 4'b1100);
    apply(32'hFFFF_0000, 32'h0000_FFFF, 4'b1100);
    apply(32'hF0F0_0000, 32'h0F0F_0000, 4'b0001);
    apply(32'hFFFF_FFFF, 32'h0000_0000, 4'b0000);
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] x, y;
      x = $urandom;
      y = (i % 7 == 0) ? x : $urandom;
      if (i % 11 == 0) x[W-1] = ~y[W-1];
      apply(x, y, OPS[i % 6]);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule